// File: doc/BRIEF.md
# Peak-Driven Stepped Gain Controller

This block keeps one shared amplifier gain setting for a group of four amplitude channels that observe the same monitor. Every time a new set of amplitude samples is strobed in, it picks the largest of the four and compares it with a programmable target window. It then moves the common gain index by a single 1 dB step, toward the window, or leaves it where it is.

The index runs from 0 to 80, which covers -12 dB to +68 dB in 1 dB steps. Index 0 is -12 dB and index 80 is +68 dB. The index is sent to the amplifier control logic outside this block, which turns it into per-stage settings.

Several controls shape the stepping:
- A hysteresis margin below the lower level stops the gain from toggling when the signal sits near that level.
- A settle count blocks further steps for a programmable number of strobes after every change.
- A hold input freezes stepping.
- A load input forces a chosen index.
- A one-cycle flag marks every index change, so downstream logic can discard the samples that the gain switch disturbed.

Top module: `peak_gain_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `gain_idx` becomes 12 (0 dB) and `gain_chg` becomes 0.
- R2: Channel k occupies bits [16k+15:16k] of `amp_bus`. The step decision uses only the largest of the four unsigned channel values, whichever channel holds it.
- R3: On a strobe that is free to step, if the peak is strictly greater than `lvl_hi`, the index is decremented by one.
- R4: On a strobe that is free to step, if the peak is strictly less than `lvl_lo - lvl_hyst` (taken as 0 when `lvl_hyst` exceeds `lvl_lo`), the index is incremented by one. A peak from that threshold up to `lvl_hi` inclusive leaves the index unchanged.
- R5: The index saturates at 0 and at 80 and never wraps.
- R6: The index changes by at most one per clock, and only on a cycle with `smp_valid` high or `load` high.
- R7: After any step or any load, the next `settle_len` strobes decrement an internal settle count and take no step. A strobe is free to step only when that count is zero.
- R8: While `hold` is high, strobes take no step. Settle counting still proceeds.
- R9: When `load` is high at a clock edge, `gain_idx` takes `load_idx`, clamped to 80. This overrides hold, settle and strobes, and restarts the settle count.
- R10: `gain_chg` is high for exactly the one cycle that follows each clock edge at which `gain_idx` changed value, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe: `amp_bus` holds a new sample set |
| amp_bus | input | 64 | Four packed unsigned 16-bit channel amplitudes |
| lvl_hi | input | 16 | Upper window level |
| lvl_lo | input | 16 | Lower window level |
| lvl_hyst | input | 16 | Hysteresis margin below the lower level |
| settle_len | input | 8 | Strobes to skip after each change |
| hold | input | 1 | Freeze stepping |
| load | input | 1 | Force `load_idx` into the index |
| load_idx | input | 7 | Index to force |
| gain_idx | output | 7 | Shared gain index, 0 = -12 dB, 80 = +68 dB |
| gain_chg | output | 1 | One-cycle flag after each index change |

## Verification
The embedded properties assume the following about the inputs:
- The window levels, the hysteresis and `settle_len` are quasi-static configuration.
- `amp_bus` is fully defined whenever it is compared, which the max-bound properties check each cycle after reset.
- `rst` is asserted from time zero, so `$past` never reaches values from before reset.

The stimulus follows these assumptions. Configuration changes only between sequences, and always while no strobe is pending. Every input is driven on the falling edge from a defined value, and `lvl_hi` stays above `lvl_lo`, so that no sample calls for a step up and a step down at once.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    // Direction requested by the window comparison for one sample set.
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

    // Default geometry of the gain index range (1 dB per code).
    localparam int PGC_IDX_MIN_DB = -12;
    localparam int PGC_IDX_MAX_DB = 68;
    localparam int PGC_IDX_CODES  = PGC_IDX_MAX_DB - PGC_IDX_MIN_DB + 1;

    // Index code that corresponds to a given gain in dB.
    function automatic int db_to_code(input int db);
        return db - PGC_IDX_MIN_DB;
    endfunction

endpackage

// File: rtl/pgc_peak.sv
module pgc_peak #(
    parameter int NCH   = 4,
    parameter int AMP_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH*AMP_W-1:0]   amp_bus,
    output logic [AMP_W-1:0]       peak
);

    logic [AMP_W-1:0] run [NCH];

    assign run[0] = amp_bus[AMP_W-1:0];

    // Running-maximum chain across the channels.
    for (genvar k = 1; k < NCH; k++) begin : g_chain
        logic [AMP_W-1:0] ch;
        assign ch     = amp_bus[k*AMP_W +: AMP_W];
        assign run[k] = (ch > run[k-1]) ? ch : run[k-1];
    end

    assign peak = run[NCH-1];

    // R2: the peak bounds every channel.
    for (genvar k = 0; k < NCH; k++) begin : g_chk
        p_peak_bound_r2: assert property (@(posedge clk) disable iff (rst)
            peak >= amp_bus[k*AMP_W +: AMP_W]);
    end

endmodule

// File: rtl/pgc_window.sv
module pgc_window
    import pgc_pkg::*;
#(
    parameter int AMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AMP_W-1:0] peak,
    input  logic [AMP_W-1:0] lvl_hi,
    input  logic [AMP_W-1:0] lvl_lo,
    input  logic [AMP_W-1:0] lvl_hyst,
    output step_dir_e        dir
);

    logic [AMP_W-1:0] up_thr;

    // Lower trip point, floored at zero.
    assign up_thr = (lvl_lo > lvl_hyst) ? (lvl_lo - lvl_hyst) : '0;

    always_comb begin
        if (peak > lvl_hi) begin
            dir = DIR_DOWN;
        end else if (peak < up_thr) begin
            dir = DIR_UP;
        end else begin
            dir = DIR_HOLD;
        end
    end

    // R4: a request to raise the gain means the peak sits below the lower level.
    p_up_below_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_UP) |-> (peak < lvl_lo));

    // R3: a request to lower the gain means the peak is not within the upper level.
    p_down_above_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_DOWN) |-> !(peak <= lvl_hi));

endmodule

// File: rtl/pgc_step.sv
module pgc_step
    import pgc_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int IDX_MIN = 0,
    parameter int IDX_MAX = 80,
    parameter int IDX_RST = 12,
    parameter int SET_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  step_dir_e        dir,
    input  logic             hold,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [SET_W-1:0] settle_len,
    output logic [IDX_W-1:0] gain_idx,
    output logic             gain_chg
);

    localparam logic [IDX_W-1:0] LO_C  = IDX_W'(IDX_MIN);
    localparam logic [IDX_W-1:0] HI_C  = IDX_W'(IDX_MAX);
    localparam logic [IDX_W-1:0] RST_C = IDX_W'(IDX_RST);

    logic [IDX_W-1:0] idx_q, idx_n, ld_c;
    logic [SET_W-1:0] cnt_q, cnt_n;
    logic             chg_q;

    // Forced index, clamped into the legal range.
    always_comb begin
        if (load_idx > HI_C) begin
            ld_c = HI_C;
        end else if (load_idx <= LO_C) begin
            ld_c = LO_C;
        end else begin
            ld_c = load_idx;
        end
    end

    always_comb begin
        idx_n = idx_q;
        cnt_n = cnt_q;
        if (load) begin
            idx_n = ld_c;
            cnt_n = settle_len;
        end else if (smp_valid) begin
            if (cnt_q != '0) begin
                cnt_n = cnt_q - 1'b1;
            end else if (!hold) begin
                unique case (dir)
                    DIR_UP:   if (idx_q < HI_C) idx_n = idx_q + 1'b1;
                    DIR_DOWN: if (idx_q > LO_C) idx_n = idx_q - 1'b1;
                    default:  idx_n = idx_q;
                endcase
                if (idx_n != idx_q) cnt_n = settle_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= RST_C;
            cnt_q <= '0;
            chg_q <= 1'b0;
        end else begin
            idx_q <= idx_n;
            cnt_q <= cnt_n;
            chg_q <= (idx_n != idx_q);
        end
    end

    assign gain_idx = idx_q;
    assign gain_chg = chg_q;

    // R5: the index stays within its range.
    p_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        (idx_q >= LO_C) && (idx_q <= HI_C));

    // R6: without a load the index moves by at most one code.
    p_one_step_r6: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((idx_q == $past(idx_q)) ||
                   (idx_q == $past(idx_q) + 1'b1) ||
                   (idx_q == $past(idx_q) - 1'b1)));

    // R6: no strobe and no load leaves the index alone.
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !load) |=> $stable(idx_q));

    // R7: a running settle count blocks steps.
    p_settle_block_r7: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q != '0) && !load) |=> $stable(idx_q));

    // R8: hold blocks steps.
    p_hold_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> $stable(idx_q));

    // R10: the change flag follows index movement by one cycle.
    p_chg_flag_r10: assert property (@(posedge clk) disable iff (rst)
        ##1 (chg_q == (idx_q != $past(idx_q))));

endmodule

// File: rtl/peak_gain_ctrl.sv
module peak_gain_ctrl
    import pgc_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int AMP_W   = 16,
    parameter int IDX_W   = 7,
    parameter int IDX_MIN = 0,
    parameter int IDX_MAX = PGC_IDX_CODES - 1,
    parameter int IDX_RST = 12,
    parameter int SET_W   = 8,
    localparam int BUS_W  = NCH * AMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [BUS_W-1:0] amp_bus,
    input  logic [AMP_W-1:0] lvl_hi,
    input  logic [AMP_W-1:0] lvl_lo,
    input  logic [AMP_W-1:0] lvl_hyst,
    input  logic [SET_W-1:0] settle_len,
    input  logic             hold,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    output logic [IDX_W-1:0] gain_idx,
    output logic             gain_chg
);

    logic [AMP_W-1:0] peak;
    step_dir_e        dir;

    pgc_peak #(.NCH(NCH), .AMP_W(AMP_W)) u_peak (
        .clk     (clk),
        .rst     (rst),
        .amp_bus (amp_bus),
        .peak    (peak)
    );

    pgc_window #(.AMP_W(AMP_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .peak     (peak),
        .lvl_hi   (lvl_hi),
        .lvl_lo   (lvl_lo),
        .lvl_hyst (lvl_hyst),
        .dir      (dir)
    );

    pgc_step #(
        .IDX_W   (IDX_W),
        .IDX_MIN (IDX_MIN),
        .IDX_MAX (IDX_MAX),
        .IDX_RST (IDX_RST),
        .SET_W   (SET_W)
    ) u_step (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .dir        (dir),
        .hold       (hold),
        .load       (load),
        .load_idx   (load_idx),
        .settle_len (settle_len),
        .gain_idx   (gain_idx),
        .gain_chg   (gain_chg)
    );

endmodule

// File: tb/sim_peak_gain_ctrl.sv
module sim_peak_gain_ctrl;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [63:0]   amp_bus = '0;
    logic [AW-1:0] lvl_hi = 16'd1000;
    logic [AW-1:0] lvl_lo = 16'd500;
    logic [AW-1:0] lvl_hyst = 16'd100;
    logic [7:0]    settle_len = 8'd0;
    logic          hold = 1'b0;
    logic          load = 1'b0;
    logic [6:0]    load_idx = '0;
    logic [6:0]    gain_idx;
    logic          gain_chg;

    peak_gain_ctrl u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .amp_bus(amp_bus),
        .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .lvl_hyst(lvl_hyst),
        .settle_len(settle_len), .hold(hold), .load(load),
        .load_idx(load_idx), .gain_idx(gain_idx), .gain_chg(gain_chg)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        logic [6:0] idx;
        logic       chg;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // Reference state derived from the requirements.
    int m_idx = 12;
    int m_cnt = 0;

    // Monitor: compare one expectation per falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (gain_idx !== e.idx || gain_chg !== e.chg) begin
                n_bad++;
                $display("FAIL %s: idx=%0d chg=%0b expected idx=%0d chg=%0b",
                         e.tag, gain_idx, gain_chg, e.idx, e.chg);
            end
        end
    end

    task automatic apply(input bit v, input int a0, input int a1, input int a2,
                         input int a3, input bit h, input bit ld, input int li,
                         input string tag);
        int   pk, thr, nidx;
        exp_t e;
        smp_valid = v;
        amp_bus   = {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
        hold      = h;
        load      = ld;
        load_idx  = 7'(li);
        pk = a0;
        if (a1 > pk) pk = a1;
        if (a2 > pk) pk = a2;
        if (a3 > pk) pk = a3;
        thr  = (int'(lvl_lo) > int'(lvl_hyst)) ? int'(lvl_lo) - int'(lvl_hyst) : 0;
        nidx = m_idx;
        if (ld) begin
            nidx  = (li > 80) ? 80 : li;
            m_cnt = int'(settle_len);
        end else if (v) begin
            if (m_cnt != 0) begin
                m_cnt--;
            end else if (!h) begin
                if (pk > int'(lvl_hi)) begin
                    if (nidx > 0) nidx--;
                end else if (pk < thr) begin
                    if (nidx < 80) nidx++;
                end
                if (nidx != m_idx) m_cnt = int'(settle_len);
            end
        end
        e.idx = 7'(nidx);
        e.chg = (nidx != m_idx);
        e.tag = tag;
        m_idx = nidx;
        @(posedge clk);
        #1;
        sb.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state.
        n_vec++;
        if (gain_idx !== 7'd12 || gain_chg !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: idx=%0d chg=%0b expected idx=12 chg=0", gain_idx, gain_chg);
        end

        // R3 / R2: largest channel above upper level steps down.
        apply(1, 10, 20, 2000, 30, 0, 0, 0, "R3");
        apply(1, 1500, 600, 600, 600, 0, 0, 0, "R2");
        apply(1, 600, 1500, 600, 600, 0, 0, 0, "R2");
        apply(1, 600, 600, 600, 1001, 0, 0, 0, "R2");
        // R2: largest channel inside the window holds although others are low.
        apply(1, 10, 900, 10, 10, 0, 0, 0, "R2");
        // R6: no strobe, no movement.
        apply(0, 5000, 5000, 5000, 5000, 0, 0, 0, "R6");
        apply(0, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R4: window and hysteresis band hold; exactly at limits hold.
        apply(1, 700, 700, 700, 700, 0, 0, 0, "R4");
        apply(1, 450, 450, 450, 450, 0, 0, 0, "R4");
        apply(1, 400, 0, 0, 0, 0, 0, 0, "R4");
        apply(1, 0, 0, 1000, 0, 0, 0, 0, "R4");
        // R4: below threshold steps up, one per strobe (R6).
        apply(1, 300, 300, 300, 300, 0, 0, 0, "R4");
        apply(1, 399, 0, 0, 0, 0, 0, 0, "R4");
        apply(1, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R8: hold freezes.
        apply(1, 2000, 0, 0, 0, 1, 0, 0, "R8");
        apply(1, 0, 0, 0, 0, 1, 0, 0, "R8");
        // R9: load forces and overrides hold; R5 low saturation.
        apply(0, 0, 0, 0, 0, 1, 1, 0, "R9");
        apply(1, 3000, 0, 0, 0, 0, 0, 0, "R5");
        apply(1, 3000, 3000, 0, 0, 0, 0, 0, "R5");
        // R9: clamp to 80; R5 high saturation.
        apply(1, 3000, 0, 0, 0, 0, 1, 120, "R9");
        apply(1, 0, 0, 0, 0, 0, 0, 0, "R5");
        apply(1, 10, 0, 0, 0, 0, 0, 0, "R5");
        apply(1, 0, 0, 0, 0, 0, 1, 80, "R10");
        // R7: settle window of three strobes.
        settle_len = 8'd3;
        apply(0, 0, 0, 0, 0, 0, 1, 40, "R9");
        apply(1, 0, 0, 0, 0, 0, 0, 0, "R7");
        apply(0, 0, 0, 0, 0, 0, 0, 0, "R7");
        apply(1, 0, 0, 0, 0, 0, 0, 0, "R7");
        apply(1, 0, 0, 0, 0, 1, 0, 0, "R7");
        apply(1, 0, 0, 0, 0, 0, 0, 0, "R7");
        apply(1, 0, 0, 0, 0, 0, 0, 0, "R7");
        apply(1, 5000, 0, 0, 0, 0, 0, 0, "R7");
        apply(1, 5000, 0, 0, 0, 0, 0, 0, "R7");
        apply(1, 5000, 0, 0, 0, 0, 0, 0, "R7");
        apply(1, 5000, 0, 0, 0, 0, 0, 0, "R10");
        // R4: hysteresis larger than lower level never steps up.
        settle_len = 8'd0;
        lvl_hyst = 16'd600;
        apply(1, 0, 0, 0, 0, 0, 0, 0, "R4");
        apply(1, 0, 0, 0, 0, 0, 0, 0, "R10");
        lvl_hyst = 16'd0;
        apply(1, 499, 0, 0, 0, 0, 0, 0, "R4");
        apply(1, 500, 0, 0, 0, 0, 0, 0, "R4");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule